// File: doc/BRIEF.md
# Clock and Power Mode Control Register

This block is a single 32-bit control and status register for clock and power management. It keeps three sticky event flags: one for PLL loss of lock, one for timer expiry and one for timer interrupts. It also holds a clock-source select, a two-bit low-power mode field, a polarity bit for the timer-expired pin, and a checkstop-reset enable that software can write only once. Software reads the whole register on `rd_data` at any time and writes it with a single full-word strobe. The three status flags are cleared by writing a one.

The register sits between the PLL, the timers and the reset logic. It turns their event pulses and levels into three outputs: a high/low clock divider select, a timer-expired pin that is gated by the power mode, and a reset request raised on checkstop. There are three synchronous active-high reset inputs, each reaching a different set of fields. Power-on reset reaches every field. Hard reset reaches everything except the PLL flag. Soft reset reaches only the write-once enable and its tracking flag.

Top module: `pwr_clk_ctl_reg`

## Requirements
- R1: While `pll_locked` is low and `sw_unlock` is low, the PLL-unlock flag (bit 0) reads 1 from the next cycle on.
- R2: While `sw_unlock` is high (a multiplier change or a deep-sleep or power-down entry ordered by software), loss of lock does not set bit 0.
- R3: Bits 0, 1 and 3 are cleared by writing 1 and are unchanged by writing 0. If a set event and a clearing write fall in the same cycle, the flag stays set.
- R4: Bit 0 is cleared only by `por_rst`. It keeps its value through `hard_rst` and `soft_rst`.
- R5: The timer-expired flag (bit 1) is set by any bit of `tmr_evt` and is set by power-on or hard reset.
- R6: The timer-interrupt flag (bit 3) is set by any bit of `tmr_evt` and is cleared by power-on or hard reset.
- R7: The clock-source bit (bit 4, cleared by hard reset) picks the low divider when it is 1. `div_low_sel` follows (clock-source AND NOT timer-interrupt flag) one cycle after the register changes.
- R8: The pin is negated only when low-power mode (bits 6:5) is 2'b11, clock-source is 0 and the timer-expired flag is 0. Otherwise it is asserted. `texp_pin` is that level XOR the polarity bit (bit 2, 0 = active high, cleared by hard reset), one cycle later.
- R9: While `lpm_wr_lock` is high, writes leave bits 6:5 unchanged.
- R10: `reset_req` is high in the cycle after `chkstop` only if the enable (bit 7) is set and `dbg_strap` was low when last sampled under power-on or hard reset.
- R11: Bit 7 takes the written value only on the first write after any reset. Any reset clears bit 7.
- R12: Register bits 31:8 read as zero. No write is accepted in a cycle in which any reset input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| hard_rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| pll_locked | input | 1 | PLL lock level |
| sw_unlock | input | 1 | Loss of lock caused by software is in progress |
| tmr_evt | input | 4 | Timer event pulses (interval timer, clock alarm, time-base alarm, decrementer) |
| chkstop | input | 1 | Processor checkstop indication |
| dbg_strap | input | 1 | Debug-enable strap, sampled under power-on or hard reset |
| lpm_wr_lock | input | 1 | Write lock for the low-power mode field, driven by another register |
| div_low_sel | output | 1 | 1 selects the low clock divider |
| texp_pin | output | 1 | Timer-expired pin, polarity applied |
| reset_req | output | 1 | Checkstop reset request |

## Verification
The hardest states to reach are those where the reset domains overlap. One example is a PLL flag that must survive a hard reset while the write-once enable is cleared and the debug strap is sampled again. Another is a clearing write that lands in the same cycle as a set event. A directed phase builds each of these on purpose. It re-arms the enable after a soft reset and after a hard reset taken with the strap high, drops lock during a clearing write, and walks the deep-sleep pin gating through both polarities. A long random phase then mixes rare resets of all three kinds into dense event and write traffic. A behavioural model is compared with the outputs on every cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int REG_W    = 32;
  localparam int LPM_W    = 2;
  localparam int B_PLL    = 0;
  localparam int B_TEXPS  = 1;
  localparam int B_POL    = 2;
  localparam int B_TMIST  = 3;
  localparam int B_CSRC   = 4;
  localparam int B_LPM_LO = 5;
  localparam int B_LPM_HI = B_LPM_LO + LPM_W - 1;
  localparam int B_CHK    = B_LPM_HI + 1;
  localparam int USED_W   = B_CHK + 1;
  localparam logic [LPM_W-1:0] LPM_DEEP = '1;

  typedef struct packed {
    logic             pol;
    logic             csrc;
    logic [LPM_W-1:0] lpm;
    logic             chk_en;
  } ctrl_t;
endpackage

// File: rtl/pcc_w1c_bit.sv
module pcc_w1c_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pcc_ctrl_fields.sv
module pcc_ctrl_fields
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_hard,
  input  logic             rst_any,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lpm_wr_lock,
  input  logic             dbg_strap,
  output ctrl_t            ctrl,
  output logic             dbg_on
);
  logic wo_used;

  always_ff @(posedge clk) begin
    if (rst_hard) begin
      ctrl.pol  <= 1'b0;
      ctrl.csrc <= 1'b0;
      ctrl.lpm  <= '0;
      dbg_on    <= dbg_strap;
    end else if (wr_ok) begin
      ctrl.pol  <= wr_data[B_POL];
      ctrl.csrc <= wr_data[B_CSRC];
      if (!lpm_wr_lock) ctrl.lpm <= wr_data[B_LPM_HI:B_LPM_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      ctrl.chk_en <= 1'b0;
      wo_used     <= 1'b0;
    end else if (wr_ok) begin
      if (!wo_used) ctrl.chk_en <= wr_data[B_CHK];
      wo_used <= 1'b1;
    end
  end
endmodule

// File: rtl/pcc_out_stage.sv
module pcc_out_stage
  import pcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_hard,
  input  logic  rst_any,
  input  ctrl_t ctrl,
  input  logic  texps,
  input  logic  tmist,
  input  logic  chkstop,
  input  logic  dbg_on,
  output logic  div_low_sel,
  output logic  texp_pin,
  output logic  reset_req
);
  logic pin_active;
  assign pin_active = !((ctrl.lpm == LPM_DEEP) && !ctrl.csrc && !texps);

  always_ff @(posedge clk) begin
    if (rst_hard) begin
      div_low_sel <= 1'b0;
      texp_pin    <= 1'b1;
    end else begin
      div_low_sel <= ctrl.csrc && !tmist;
      texp_pin    <= pin_active ^ ctrl.pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) reset_req <= 1'b0;
    else         reset_req <= ctrl.chk_en && !dbg_on && chkstop;
  end
endmodule

// File: rtl/pwr_clk_ctl_reg.sv
module pwr_clk_ctl_reg
  import pcc_pkg::*;
#(
  parameter int N_TMR = 4
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             hard_rst,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pll_locked,
  input  logic             sw_unlock,
  input  logic [N_TMR-1:0] tmr_evt,
  input  logic             chkstop,
  input  logic             dbg_strap,
  input  logic             lpm_wr_lock,
  output logic             div_low_sel,
  output logic             texp_pin,
  output logic             reset_req
);
  localparam int N_FLAGS = 3;

  logic rst_hard, rst_any, wr_ok, tmr_any;
  logic [N_FLAGS-1:0] f_rst, f_set, f_clr, f_q;
  ctrl_t ctrl;
  logic  dbg_on;
  logic  unused_wr_hi;

  assign rst_hard = por_rst || hard_rst;
  assign rst_any  = rst_hard || soft_rst;
  assign wr_ok    = wr_en && !rst_any;
  assign tmr_any  = |tmr_evt;
  assign unused_wr_hi = ^wr_data[REG_W-1:USED_W];

  // flag 0: PLL unlock, flag 1: timer expired, flag 2: timer interrupt
  assign f_rst = {rst_hard, rst_hard, por_rst};
  assign f_set = {tmr_any, tmr_any, !pll_locked && !sw_unlock};
  assign f_clr = {wr_ok && wr_data[B_TMIST], wr_ok && wr_data[B_TEXPS],
                  wr_ok && wr_data[B_PLL]};

  localparam logic [N_FLAGS-1:0] F_RST_VAL = 3'b010;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    pcc_w1c_bit #(.RST_VAL(F_RST_VAL[g])) u_bit (
      .clk(clk), .rst(f_rst[g]), .set_i(f_set[g]), .clr_i(f_clr[g]), .flag_o(f_q[g])
    );
  end

  pcc_ctrl_fields u_ctrl (
    .clk(clk), .rst_hard(rst_hard), .rst_any(rst_any), .wr_ok(wr_ok),
    .wr_data(wr_data), .lpm_wr_lock(lpm_wr_lock), .dbg_strap(dbg_strap),
    .ctrl(ctrl), .dbg_on(dbg_on)
  );

  pcc_out_stage u_out (
    .clk(clk), .rst_hard(rst_hard), .rst_any(rst_any), .ctrl(ctrl),
    .texps(f_q[1]), .tmist(f_q[2]), .chkstop(chkstop), .dbg_on(dbg_on),
    .div_low_sel(div_low_sel), .texp_pin(texp_pin), .reset_req(reset_req)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[B_PLL]             = f_q[0];
    rd_data[B_TEXPS]           = f_q[1];
    rd_data[B_POL]             = ctrl.pol;
    rd_data[B_TMIST]           = f_q[2];
    rd_data[B_CSRC]            = ctrl.csrc;
    rd_data[B_LPM_HI:B_LPM_LO] = ctrl.lpm;
    rd_data[B_CHK]             = ctrl.chk_en;
  end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int N_TMR = 4
) (
  input logic             clk,
  input logic             por_rst,
  input logic             hard_rst,
  input logic             soft_rst,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic             pll_locked,
  input logic             sw_unlock,
  input logic [N_TMR-1:0] tmr_evt,
  input logic             lpm_wr_lock,
  input logic             div_low_sel,
  input logic             reset_req
);
  a_r1_unlock_sets: assert property (@(posedge clk) disable iff (por_rst)
    (!pll_locked && !sw_unlock) |=> rd_data[B_PLL]);

  a_r2_sw_unlock_quiet: assert property (@(posedge clk) disable iff (por_rst)
    ((pll_locked || sw_unlock) && !rd_data[B_PLL]) |=> !rd_data[B_PLL]);

  a_r4_hard_keeps_pll: assert property (@(posedge clk) disable iff (por_rst)
    (hard_rst && pll_locked) |=> $stable(rd_data[B_PLL]));

  a_r6_tmist_sets: assert property (@(posedge clk) disable iff (por_rst || hard_rst)
    (|tmr_evt) |=> rd_data[B_TMIST]);

  a_r7_tmist_holds_high: assert property (@(posedge clk) disable iff (por_rst || hard_rst)
    rd_data[B_TMIST] |=> !div_low_sel);

  a_r9_lpm_locked: assert property (@(posedge clk) disable iff (por_rst || hard_rst)
    (lpm_wr_lock || !wr_en) |=> $stable(rd_data[B_LPM_HI:B_LPM_LO]));

  a_r10_no_enable_no_req: assert property (@(posedge clk)
    disable iff (por_rst || hard_rst || soft_rst)
    !rd_data[B_CHK] |=> !reset_req);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (por_rst)
    rd_data[REG_W-1:USED_W] == '0);
endmodule

bind pwr_clk_ctl_reg pcc_checker u_pcc_chk (
  .clk(clk), .por_rst(por_rst), .hard_rst(hard_rst), .soft_rst(soft_rst),
  .wr_en(wr_en), .rd_data(rd_data), .pll_locked(pll_locked), .sw_unlock(sw_unlock),
  .tmr_evt(tmr_evt), .lpm_wr_lock(lpm_wr_lock), .div_low_sel(div_low_sel),
  .reset_req(reset_req)
);

// File: tb/pwr_clk_ctl_reg_test.sv
`timescale 1ns/1ps
module pwr_clk_ctl_reg_test;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, hard_rst = 1'b0, soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pll_locked = 1'b1, sw_unlock = 1'b0;
  logic [3:0]  tmr_evt = '0;
  logic        chkstop = 1'b0, dbg_strap = 1'b0, lpm_wr_lock = 1'b0;
  logic        div_low_sel, texp_pin, reset_req;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  pwr_clk_ctl_reg uut (
    .clk(clk), .por_rst(por_rst), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_locked(pll_locked), .sw_unlock(sw_unlock), .tmr_evt(tmr_evt),
    .chkstop(chkstop), .dbg_strap(dbg_strap), .lpm_wr_lock(lpm_wr_lock),
    .div_low_sel(div_low_sel), .texp_pin(texp_pin), .reset_req(reset_req)
  );

  // Behavioural reference model, stepped on each rising edge
  bit m_pll, m_texps, m_tmist, m_pol, m_csrc, m_chk, m_wo, m_dbg;
  bit [1:0] m_lpm;
  bit m_div, m_pin = 1, m_req;

  always @(posedge clk) begin
    bit hrd, any, wok;
    hrd = por_rst | hard_rst;
    any = hrd | soft_rst;
    wok = wr_en & !any;
    cyc++;
    if (hrd) begin m_div = 0; m_pin = 1; end
    else begin
      m_div = m_csrc & !m_tmist;
      m_pin = !(m_lpm == 2'd3 && !m_csrc && !m_texps) ^ m_pol;
    end
    m_req = any ? 0 : (m_chk & !m_dbg & chkstop);
    if (por_rst) m_pll = 0;
    else if (!pll_locked && !sw_unlock) m_pll = 1;
    else if (wok && wr_data[0]) m_pll = 0;
    if (hrd) m_texps = 1;
    else if (tmr_evt != 0) m_texps = 1;
    else if (wok && wr_data[1]) m_texps = 0;
    if (hrd) m_tmist = 0;
    else if (tmr_evt != 0) m_tmist = 1;
    else if (wok && wr_data[3]) m_tmist = 0;
    if (hrd) begin m_pol = 0; m_csrc = 0; m_lpm = 0; m_dbg = dbg_strap; end
    else if (wok) begin
      m_pol = wr_data[2]; m_csrc = wr_data[4];
      if (!lpm_wr_lock) m_lpm = wr_data[6:5];
    end
    if (any) begin m_chk = 0; m_wo = 0; end
    else if (wok) begin
      if (!m_wo) m_chk = wr_data[7];
      m_wo = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R1 R2 R3 R4 pll flag", 32'(rd_data[0]), 32'(m_pll));
    chk("R3 R5 timer-expired flag", 32'(rd_data[1]), 32'(m_texps));
    chk("R3 R6 timer-interrupt flag", 32'(rd_data[3]), 32'(m_tmist));
    chk("R7 clock-source bit", 32'(rd_data[4]), 32'(m_csrc));
    chk("R8 polarity bit", 32'(rd_data[2]), 32'(m_pol));
    chk("R9 low-power field", 32'(rd_data[6:5]), 32'(m_lpm));
    chk("R11 checkstop enable", 32'(rd_data[7]), 32'(m_chk));
    chk("R12 reserved bits", {8'd0, rd_data[31:8]}, 32'd0);
    chk("R7 div_low_sel", 32'(div_low_sel), 32'(m_div));
    chk("R8 texp_pin", 32'(texp_pin), 32'(m_pin));
    chk("R10 reset_req", 32'(reset_req), 32'(m_req));
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d;
    idle(1);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    idle(2);
    started = 1;
    por_rst = 0;
    idle(2);
    wr(32'h90);                                 // R11 first write arms enable, R7 csrc=1
    idle(3);
    tmr_evt = 4'b0100; idle(1); tmr_evt = 0;    // R6 interrupt flag overrides R7
    idle(2);
    wr(32'h98);                                 // R3 clear tmist, keep csrc
    idle(2);
    chkstop = 1; idle(1); chkstop = 0;          // R10 request expected
    idle(2);
    wr(32'h00);                                 // R11 second write ignored for bit 7
    chkstop = 1; idle(1); chkstop = 0;
    pll_locked = 0; sw_unlock = 1; idle(2);     // R2
    sw_unlock = 0; idle(1); pll_locked = 1;     // R1
    wr(32'h00);                                 // R3 zero leaves flag
    wr(32'h01);                                 // R3 clear
    pll_locked = 0; idle(1); pll_locked = 1;
    hard_rst = 1; idle(2); hard_rst = 0;        // R4 flag survives
    pll_locked = 0; wr(32'h01); pll_locked = 1; // R3 set wins
    tmr_evt = 4'b0001; wr(32'h0A); tmr_evt = 0; // R3 set wins for timer flags
    lpm_wr_lock = 1; wr(32'h60); lpm_wr_lock = 0; // R9
    wr(32'h60);                                 // deep sleep, texps still 1: R8
    wr(32'h62); idle(2);                        // clear texps -> pin negated
    wr(32'h64); idle(2);                        // R8 active-low polarity
    tmr_evt = 4'b1000; idle(1); tmr_evt = 0; idle(2);
    dbg_strap = 1; hard_rst = 1; idle(1); hard_rst = 0; dbg_strap = 0;
    wr(32'h80); chkstop = 1; idle(2); chkstop = 0; // R10 debug blocks request
    soft_rst = 1; idle(1); soft_rst = 0;        // R11 soft reset re-arms
    wr(32'h80); chkstop = 1; idle(1); chkstop = 0;
    por_rst = 1; wr(32'hFFFF_FFFF); por_rst = 0; // R12 write in reset ignored
    wr(32'hFFFF_FF00); idle(2);
    for (int i = 0; i < 3000; i++) begin
      por_rst     = ($urandom_range(0, 299) == 0);
      hard_rst    = ($urandom_range(0, 99) == 0);
      soft_rst    = ($urandom_range(0, 79) == 0);
      dbg_strap   = $urandom_range(0, 1);
      wr_en       = ($urandom_range(0, 3) == 0);
      wr_data     = $urandom;
      pll_locked  = ($urandom_range(0, 9) != 0);
      sw_unlock   = ($urandom_range(0, 2) == 0);
      tmr_evt     = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'd0;
      chkstop     = ($urandom_range(0, 4) == 0);
      lpm_wr_lock = $urandom_range(0, 1);
      idle(1);
    end
    {por_rst, hard_rst, soft_rst, wr_en, chkstop} = '0;
    tmr_evt = 0; pll_locked = 1;
    idle(3);
    finish_run();
  end
endmodule